// File: doc/BRIEF.md
# Multi-Lane Antenna Cross-Product Integrator

This block is the multiply-and-integrate stage of a frequency-domain correlator. Spectra arrive already split into frequency channels. Each parallel lane holds the complex samples of one channel for every antenna, across several integration steps and several time taps per step. The samples are loaded beforehand through a single write port. A start pulse then makes every lane walk the same fixed list of antenna pairs, one pair per clock. For each pair and step, a lane multiplies one antenna's sample by the conjugate of the other's, for every tap. It adds the tap products together and accumulates that sum into a saturating integrator for the pair.

All steps are walked first. The integrated visibilities then leave through one registered output stream, one word per clock. Each word carries the channel, the pair number and the two antenna numbers. Arithmetic is signed fixed point throughout. A busy flag brackets the whole operation.

Top module: `xcorr_engine`

## Requirements
- R1: For NANT antennas each channel yields NANT*(NANT+1)/2 words, one per pair (a,b) with a <= b (autocorrelations included). Pairs are ordered with a as the outer index and b as the inner index, and the pair number counts up from 0 in that order.
- R2: Samples are 8-bit two's complement real and imaginary parts. A pair's product is A times the conjugate of B: real = Ar*Br + Ai*Bi, imaginary = Ai*Br - Ar*Bi, where A is antenna a and B is antenna b.
- R3: For each integration step, a word's contribution is the sum of the NTAP tap products of that step. The word is the integral of these contributions over all steps of the run.
- R4: The step count is taken from int_len when start is accepted. A value of 0 counts as 1, and a value above MAXSTEP counts as MAXSTEP.
- R5: Accumulators are ACC_W-bit signed. After every step's addition they clamp to 2^(ACC_W-1)-1 or -2^(ACC_W-1) instead of wrapping.
- R6: Lanes are independent. Lane L uses only the samples written with wr_lane = L, and its words carry vis_chan = L. Output is channel-major: all pairs of lane 0, then lane 1, and so on, on consecutive cycles.
- R7: An accepted start clears all accumulators, so a rerun on unchanged samples gives the same words again.
- R8: busy is low after reset. It rises on the cycle after the accepting start edge, stays high through the cycle of the last output word, and is low on the cycle after it. vis_valid is never high while busy is low.
- R9: A start pulse or an int_len change while busy has no effect on the running operation.
- R10: Sample writes (wr_en with lane, step, tap and antenna selecting one buffer word) are ignored while busy. Stored samples persist from run to run.
- R11: With K = steps * NANT*(NANT+1)/2, the first word is valid K+4 cycles after the clock edge that accepts start. The last word is valid K+3+NLANE*NANT*(NANT+1)/2 cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Sample write strobe |
| wr_lane | input | LANE_W | Lane (channel) of the write |
| wr_step | input | STEP_W | Integration step of the write |
| wr_tap | input | TAP_W | Time tap of the write |
| wr_ant | input | ANT_W | Antenna of the write |
| wr_re | input | SW | Real part of the sample |
| wr_im | input | SW | Imaginary part of the sample |
| start | input | 1 | Start pulse: clear and run |
| int_len | input | LEN_W | Number of integration steps |
| busy | output | 1 | Operation in progress |
| vis_valid | output | 1 | Output word valid |
| vis_chan | output | LANE_W | Channel (lane) of the word |
| vis_bl | output | BL_W | Pair number within the channel |
| vis_ant_a | output | ANT_W | First antenna of the pair |
| vis_ant_b | output | ANT_W | Second antenna of the pair |
| vis_re | output | ACC_W | Integrated real part |
| vis_im | output | ACC_W | Integrated imaginary part |

## Verification
Two events can meet in the same cycle: a new start pulse or sample write, and the running walk of pairs. The walk is either issuing reads from the sample buffers or streaming words out. The bench provokes this by asserting start with a different int_len, together with a write of fresh data into a buffer word that the run is using, while the block is busy. It judges the outcome from the words that come out. Their values and timing must match a model that never saw the interfering write or the second start, and they must equal the words of the previous run on the same samples.

// File: rtl/xc_pkg.sv
package xc_pkg;

  // Bit width able to index n items, never below one.
  function automatic int bitw(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // Number of antenna pairs including autocorrelations.
  function automatic int pair_count(input int n);
    return n * (n + 1) / 2;
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_EMIT,
    ST_FLUSH
  } xc_state_e;

endpackage

// File: rtl/xc_sample_ram.sv
module xc_sample_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/xc_ctrl.sv
module xc_ctrl
  import xc_pkg::*;
#(
  parameter int NANT     = 4,
  parameter int NLANE    = 4,
  parameter int MAXSTEP  = 4,
  parameter int PIPE_LAT = 3,
  parameter int ANT_W    = 2,
  parameter int STEP_W   = 2,
  parameter int LANE_W   = 2,
  parameter int BL_W     = 4,
  parameter int LEN_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  int_len,
  output logic              busy,
  output logic              clr,
  output logic              iss,
  output logic [STEP_W-1:0] iss_step,
  output logic [ANT_W-1:0]  pair_a,
  output logic [ANT_W-1:0]  pair_b,
  output logic [BL_W-1:0]   pair_idx,
  output logic              emit,
  output logic [LANE_W-1:0] em_lane
);

  localparam int DCW = bitw(PIPE_LAT);

  xc_state_e         st;
  logic [STEP_W-1:0] step_q, last_step;
  logic [LANE_W-1:0] lane_q;
  logic [DCW-1:0]    dcnt;
  logic [ANT_W-1:0]  pa, pb, na, nb;
  logic [BL_W-1:0]   pbl;
  logic              pair_last;
  logic [LEN_W-1:0]  len_c;

  // Next pair in the walk: b inner, a outer, a <= b.
  always_comb begin
    pair_last = (pa == ANT_W'(NANT - 1));
    if (pb == ANT_W'(NANT - 1)) begin
      na = pa + 1'b1;
      nb = pa + 1'b1;
    end else begin
      na = pa;
      nb = pb + 1'b1;
    end
  end

  // Step count clamped into 1..MAXSTEP.
  always_comb begin
    if (int_len == '0)                      len_c = LEN_W'(1);
    else if (int_len > LEN_W'(MAXSTEP))     len_c = LEN_W'(MAXSTEP);
    else                                    len_c = int_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      step_q    <= '0;
      last_step <= '0;
      lane_q    <= '0;
      dcnt      <= '0;
      pa        <= '0;
      pb        <= '0;
      pbl       <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            st        <= ST_RUN;
            last_step <= STEP_W'(len_c - 1'b1);
            step_q    <= '0;
            pa        <= '0;
            pb        <= '0;
            pbl       <= '0;
          end
        end
        ST_RUN: begin
          if (pair_last) begin
            pa  <= '0;
            pb  <= '0;
            pbl <= '0;
            if (step_q == last_step) begin
              st   <= ST_DRAIN;
              dcnt <= '0;
            end else begin
              step_q <= step_q + 1'b1;
            end
          end else begin
            pa  <= na;
            pb  <= nb;
            pbl <= pbl + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (dcnt == DCW'(PIPE_LAT - 1)) begin
            st     <= ST_EMIT;
            lane_q <= '0;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        ST_EMIT: begin
          if (pair_last) begin
            pa  <= '0;
            pb  <= '0;
            pbl <= '0;
            if (lane_q == LANE_W'(NLANE - 1)) st <= ST_FLUSH;
            else                              lane_q <= lane_q + 1'b1;
          end else begin
            pa  <= na;
            pb  <= nb;
            pbl <= pbl + 1'b1;
          end
        end
        ST_FLUSH: st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign clr      = (st == ST_IDLE) && start;
  assign iss      = (st == ST_RUN);
  assign emit     = (st == ST_EMIT);
  assign iss_step = step_q;
  assign pair_a   = pa;
  assign pair_b   = pb;
  assign pair_idx = pbl;
  assign em_lane  = lane_q;

endmodule

// File: rtl/xc_lane.sv
module xc_lane
  import xc_pkg::*;
#(
  parameter int NANT    = 4,
  parameter int NTAP    = 3,
  parameter int MAXSTEP = 4,
  parameter int SW      = 8,
  parameter int ACC_W   = 32,
  parameter int ANT_W   = 2,
  parameter int STEP_W  = 2,
  parameter int TAP_W   = 2,
  parameter int BL_W    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    we,
  input  logic [STEP_W-1:0]       w_step,
  input  logic [TAP_W-1:0]        w_tap,
  input  logic [ANT_W-1:0]        w_ant,
  input  logic [SW-1:0]           w_re,
  input  logic [SW-1:0]           w_im,
  input  logic                    iss,
  input  logic [STEP_W-1:0]       iss_step,
  input  logic [ANT_W-1:0]        iss_a,
  input  logic [ANT_W-1:0]        iss_b,
  input  logic [BL_W-1:0]         iss_bl,
  input  logic [BL_W-1:0]         rd_bl,
  output logic signed [ACC_W-1:0] rd_re,
  output logic signed [ACC_W-1:0] rd_im
);

  localparam int NB    = pair_count(NANT);
  localparam int DEPTH = MAXSTEP * NANT;
  localparam int MA_W  = bitw(DEPTH);
  localparam int PR_W  = 2 * SW + 1;
  localparam int SUM_W = PR_W + bitw(NTAP);

  logic [MA_W-1:0] waddr, raddr_a, raddr_b;
  assign waddr   = MA_W'(int'(w_step) * NANT + int'(w_ant));
  assign raddr_a = MA_W'(int'(iss_step) * NANT + int'(iss_a));
  assign raddr_b = MA_W'(int'(iss_step) * NANT + int'(iss_b));

  logic [2*SW-1:0]       qa [NTAP];
  logic [2*SW-1:0]       qb [NTAP];
  logic signed [SW-1:0]  a_re [NTAP], a_im [NTAP], b_re [NTAP], b_im [NTAP];

  // Two copies of each tap buffer give two independent read ports.
  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    logic tap_we;
    assign tap_we = we && (w_tap == TAP_W'(t));

    xc_sample_ram #(.DW(2 * SW), .DEPTH(DEPTH), .AW(MA_W)) ram_a_i (
      .clk(clk), .we(tap_we), .waddr(waddr), .wdata({w_re, w_im}),
      .raddr(raddr_a), .rdata(qa[t])
    );
    xc_sample_ram #(.DW(2 * SW), .DEPTH(DEPTH), .AW(MA_W)) ram_b_i (
      .clk(clk), .we(tap_we), .waddr(waddr), .wdata({w_re, w_im}),
      .raddr(raddr_b), .rdata(qb[t])
    );

    assign a_re[t] = qa[t][2*SW-1:SW];
    assign a_im[t] = qa[t][SW-1:0];
    assign b_re[t] = qb[t][2*SW-1:SW];
    assign b_im[t] = qb[t][SW-1:0];
  end

  // Pipeline tags
  logic            v1, v2, v3;
  logic [BL_W-1:0] bl1, bl2, bl3;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      bl1 <= '0;  bl2 <= '0;  bl3 <= '0;
    end else begin
      v1  <= iss;  bl1 <= iss_bl;
      v2  <= v1;   bl2 <= bl1;
      v3  <= v2;   bl3 <= bl2;
    end
  end

  // Stage 2: per-tap conjugate products
  logic signed [PR_W-1:0] p_re [NTAP];
  logic signed [PR_W-1:0] p_im [NTAP];

  always_ff @(posedge clk) begin
    for (int t = 0; t < NTAP; t++) begin
      p_re[t] <= PR_W'(a_re[t]) * PR_W'(b_re[t]) + PR_W'(a_im[t]) * PR_W'(b_im[t]);
      p_im[t] <= PR_W'(a_im[t]) * PR_W'(b_re[t]) - PR_W'(a_re[t]) * PR_W'(b_im[t]);
    end
  end

  // Stage 3: sum over taps
  logic signed [SUM_W-1:0] s_re, s_im, sum_re, sum_im;

  always_comb begin
    s_re = '0;
    s_im = '0;
    for (int t = 0; t < NTAP; t++) begin
      s_re = s_re + SUM_W'(p_re[t]);
      s_im = s_im + SUM_W'(p_im[t]);
    end
  end

  always_ff @(posedge clk) begin
    sum_re <= s_re;
    sum_im <= s_im;
  end

  // Saturating integration
  function automatic logic signed [ACC_W-1:0] sat_add(
    input logic signed [ACC_W-1:0] a,
    input logic signed [SUM_W-1:0] b
  );
    logic signed [ACC_W:0] s;
    s = (ACC_W + 1)'(a) + (ACC_W + 1)'(b);
    if (s[ACC_W] != s[ACC_W-1])
      return s[ACC_W] ? {1'b1, {(ACC_W - 1){1'b0}}} : {1'b0, {(ACC_W - 1){1'b1}}};
    return s[ACC_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] acc_re [NB];
  logic signed [ACC_W-1:0] acc_im [NB];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int b = 0; b < NB; b++) begin
        acc_re[b] <= '0;
        acc_im[b] <= '0;
      end
    end else if (v3) begin
      acc_re[bl3] <= sat_add(acc_re[bl3], sum_re);
      acc_im[bl3] <= sat_add(acc_im[bl3], sum_im);
    end
  end

  assign rd_re = acc_re[rd_bl];
  assign rd_im = acc_im[rd_bl];

endmodule

// File: rtl/xcorr_engine.sv
module xcorr_engine
  import xc_pkg::*;
#(
  parameter  int NANT    = 4,
  parameter  int NLANE   = 4,
  parameter  int NTAP    = 3,
  parameter  int MAXSTEP = 4,
  parameter  int SW      = 8,
  parameter  int ACC_W   = 32,
  localparam int ANT_W   = bitw(NANT),
  localparam int LANE_W  = bitw(NLANE),
  localparam int STEP_W  = bitw(MAXSTEP),
  localparam int TAP_W   = bitw(NTAP),
  localparam int BL_W    = bitw(pair_count(NANT)),
  localparam int LEN_W   = bitw(MAXSTEP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [STEP_W-1:0] wr_step,
  input  logic [TAP_W-1:0]  wr_tap,
  input  logic [ANT_W-1:0]  wr_ant,
  input  logic [SW-1:0]     wr_re,
  input  logic [SW-1:0]     wr_im,
  input  logic              start,
  input  logic [LEN_W-1:0]  int_len,
  output logic              busy,
  output logic              vis_valid,
  output logic [LANE_W-1:0] vis_chan,
  output logic [BL_W-1:0]   vis_bl,
  output logic [ANT_W-1:0]  vis_ant_a,
  output logic [ANT_W-1:0]  vis_ant_b,
  output logic [ACC_W-1:0]  vis_re,
  output logic [ACC_W-1:0]  vis_im
);

  // Registers from issue to accumulator write: RAM read, product, tap sum.
  localparam int PIPE_LAT = 3;

  logic              clr, iss, emit;
  logic [STEP_W-1:0] iss_step;
  logic [ANT_W-1:0]  pair_a, pair_b;
  logic [BL_W-1:0]   pair_idx;
  logic [LANE_W-1:0] em_lane;

  xc_ctrl #(
    .NANT(NANT), .NLANE(NLANE), .MAXSTEP(MAXSTEP), .PIPE_LAT(PIPE_LAT),
    .ANT_W(ANT_W), .STEP_W(STEP_W), .LANE_W(LANE_W), .BL_W(BL_W), .LEN_W(LEN_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .int_len(int_len),
    .busy(busy), .clr(clr), .iss(iss), .iss_step(iss_step),
    .pair_a(pair_a), .pair_b(pair_b), .pair_idx(pair_idx),
    .emit(emit), .em_lane(em_lane)
  );

  logic signed [ACC_W-1:0] lane_re [NLANE];
  logic signed [ACC_W-1:0] lane_im [NLANE];

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic lane_we;
    assign lane_we = wr_en && !busy && (wr_lane == LANE_W'(l));

    xc_lane #(
      .NANT(NANT), .NTAP(NTAP), .MAXSTEP(MAXSTEP), .SW(SW), .ACC_W(ACC_W),
      .ANT_W(ANT_W), .STEP_W(STEP_W), .TAP_W(TAP_W), .BL_W(BL_W)
    ) lane_i (
      .clk(clk), .rst(rst), .clr(clr),
      .we(lane_we), .w_step(wr_step), .w_tap(wr_tap), .w_ant(wr_ant),
      .w_re(wr_re), .w_im(wr_im),
      .iss(iss), .iss_step(iss_step), .iss_a(pair_a), .iss_b(pair_b),
      .iss_bl(pair_idx), .rd_bl(pair_idx),
      .rd_re(lane_re[l]), .rd_im(lane_im[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vis_valid <= 1'b0;
      vis_chan  <= '0;
      vis_bl    <= '0;
      vis_ant_a <= '0;
      vis_ant_b <= '0;
      vis_re    <= '0;
      vis_im    <= '0;
    end else begin
      vis_valid <= emit;
      if (emit) begin
        vis_chan  <= em_lane;
        vis_bl    <= pair_idx;
        vis_ant_a <= pair_a;
        vis_ant_b <= pair_b;
        vis_re    <= lane_re[em_lane];
        vis_im    <= lane_im[em_lane];
      end
    end
  end

endmodule

// File: rtl/xc_checker.sv
module xc_checker
  import xc_pkg::*;
#(
  parameter int NANT  = 4,
  parameter int NLANE = 4,
  parameter int ACC_W = 32,
  localparam int ANT_W  = bitw(NANT),
  localparam int LANE_W = bitw(NLANE),
  localparam int BL_W   = bitw(pair_count(NANT))
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              vis_valid,
  input logic [LANE_W-1:0] vis_chan,
  input logic [BL_W-1:0]   vis_bl,
  input logic [ANT_W-1:0]  vis_ant_a,
  input logic [ANT_W-1:0]  vis_ant_b,
  input logic [ACC_W-1:0]  vis_im
);

  localparam int NB = pair_count(NANT);

  logic last_word;
  assign last_word = vis_valid && (vis_chan == LANE_W'(NLANE - 1)) && (vis_bl == BL_W'(NB - 1));

  // R8: output words only inside the busy window
  a_r8_valid_inside_busy: assert property (@(posedge clk) disable iff (rst)
    vis_valid |-> busy);

  // R8: an accepted start raises busy on the next cycle
  a_r8_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R8: busy falls only right after the final word
  a_r8_busy_drop_after_last: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(last_word));

  // R6: words stream on consecutive cycles until the last one
  a_r6_contiguous_emit: assert property (@(posedge clk) disable iff (rst)
    (vis_valid && !last_word) |=> vis_valid);

  // R1: pair numbers count up within a channel, first antenna never above second
  a_r1_pair_step: assert property (@(posedge clk) disable iff (rst)
    (vis_valid && $past(vis_valid) && vis_chan == $past(vis_chan)) |->
      (vis_bl == $past(vis_bl) + BL_W'(1)));

  a_r1_pair_order: assert property (@(posedge clk) disable iff (rst)
    vis_valid |-> (vis_ant_a <= vis_ant_b));

  // R2: an autocorrelation has zero imaginary part
  a_r2_auto_imag_zero: assert property (@(posedge clk) disable iff (rst)
    (vis_valid && vis_ant_a == vis_ant_b) |-> (vis_im == '0));

endmodule

bind xcorr_engine xc_checker #(.NANT(NANT), .NLANE(NLANE), .ACC_W(ACC_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .vis_valid(vis_valid),
  .vis_chan(vis_chan), .vis_bl(vis_bl), .vis_ant_a(vis_ant_a),
  .vis_ant_b(vis_ant_b), .vis_im(vis_im)
);

// File: tb/xcorr_engine_tb_top.sv
module xcorr_engine_tb_top;

  localparam int CLK_P   = 10;
  localparam int NANT    = 4;
  localparam int NLANE   = 4;
  localparam int NTAP    = 3;
  localparam int MAXSTEP = 4;
  localparam int SW      = 8;
  localparam int ACC_W   = 19;
  localparam int NB      = NANT * (NANT + 1) / 2;
  localparam longint LIM = longint'(1) << (ACC_W - 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_lane = '0, wr_step = '0, wr_tap = '0, wr_ant = '0;
  logic [SW-1:0]     wr_re = '0, wr_im = '0;
  logic              start = 1'b0;
  logic [2:0]        int_len = '0;
  logic              busy, vis_valid;
  logic [1:0]        vis_chan, vis_ant_a, vis_ant_b;
  logic [3:0]        vis_bl;
  logic [ACC_W-1:0]  vis_re, vis_im;

  always #(CLK_P / 2) clk = ~clk;

  xcorr_engine #(
    .NANT(NANT), .NLANE(NLANE), .NTAP(NTAP), .MAXSTEP(MAXSTEP), .SW(SW), .ACC_W(ACC_W)
  ) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_lane(wr_lane), .wr_step(wr_step),
    .wr_tap(wr_tap), .wr_ant(wr_ant), .wr_re(wr_re), .wr_im(wr_im),
    .start(start), .int_len(int_len), .busy(busy), .vis_valid(vis_valid),
    .vis_chan(vis_chan), .vis_bl(vis_bl), .vis_ant_a(vis_ant_a),
    .vis_ant_b(vis_ant_b), .vis_re(vis_re), .vis_im(vis_im)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;
  int  m_re [NLANE][MAXSTEP][NTAP][NANT];
  int  m_im [NLANE][MAXSTEP][NTAP][NANT];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > LIM - 1) return LIM - 1;
    if (v < -LIM)    return -LIM;
    return v;
  endfunction

  function automatic longint exp_re(input int l, input int a, input int b, input int n);
    longint acc = 0;
    for (int s = 0; s < n; s++) begin
      longint ps = 0;
      for (int t = 0; t < NTAP; t++)
        ps += m_re[l][s][t][a] * m_re[l][s][t][b] + m_im[l][s][t][a] * m_im[l][s][t][b];
      acc = sat(acc + ps);
    end
    return acc;
  endfunction

  function automatic longint exp_im(input int l, input int a, input int b, input int n);
    longint acc = 0;
    for (int s = 0; s < n; s++) begin
      longint ps = 0;
      for (int t = 0; t < NTAP; t++)
        ps += m_im[l][s][t][a] * m_re[l][s][t][b] - m_re[l][s][t][a] * m_im[l][s][t][b];
      acc = sat(acc + ps);
    end
    return acc;
  endfunction

  task automatic put(input int l, input int s, input int t, input int a, input int re, input int im);
    @(negedge clk);
    wr_en = 1'b1; wr_lane = 2'(l); wr_step = 2'(s); wr_tap = 2'(t); wr_ant = 2'(a);
    wr_re = SW'(re); wr_im = SW'(im);
    m_re[l][s][t][a] = re;
    m_im[l][s][t][a] = im;
  endtask

  task automatic put_end();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fill_random();
    for (int l = 0; l < NLANE; l++)
      for (int s = 0; s < MAXSTEP; s++)
        for (int t = 0; t < NTAP; t++)
          for (int a = 0; a < NANT; a++)
            put(l, s, t, a, int'($urandom_range(0, 255)) - 128, int'($urandom_range(0, 255)) - 128);
    put_end();
  endtask

  // Runs the block, checks every word, its timing and busy.
  task automatic run(input int len_in, input int eff, input bit disturb, input string req);
    int  k = eff * NB;
    int  w = NLANE * NB;
    int  words = 0;
    int  el = 0, ebl = 0, ea = 0, eb = 0;
    bit  lat_ok = 1, busy_ok = 1;
    @(negedge clk);
    int_len = 3'(len_in);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n <= k + w + 6; n++) begin
      bit ev, eby;
      if (n > 0) @(negedge clk);
      eby = (n <= k + 3 + w);
      ev  = (n >= k + 4) && (n <= k + 3 + w);
      if (busy !== eby) busy_ok = 0;
      if (vis_valid !== ev) lat_ok = 0;
      if (vis_valid === 1'b1 && el < NLANE) begin
        longint xr = exp_re(el, ea, eb, eff);
        longint xi = exp_im(el, ea, eb, eff);
        chk(vis_chan == 2'(el) && vis_bl == 4'(ebl) && vis_ant_a == 2'(ea) && vis_ant_b == 2'(eb),
            "R1,R6", "tags chan*1000+bl*100+a*10+b",
            longint'(vis_chan) * 1000 + longint'(vis_bl) * 100 + longint'(vis_ant_a) * 10 + longint'(vis_ant_b),
            longint'(el) * 1000 + longint'(ebl) * 100 + longint'(ea) * 10 + longint'(eb));
        chk(longint'($signed(vis_re)) == xr, req, "real", longint'($signed(vis_re)), xr);
        chk(longint'($signed(vis_im)) == xi, req, "imag", longint'($signed(vis_im)), xi);
        words++;
        ebl++;
        if (eb == NANT - 1) begin ea++; eb = ea; end else eb++;
        if (ebl == NB) begin ebl = 0; ea = 0; eb = 0; el++; end
      end
      // R9 and R10: interfere while busy
      if (disturb && n == 3) begin
        start = 1'b1; int_len = 3'd1;
        wr_en = 1'b1; wr_lane = 2'd0; wr_step = 2'd0; wr_tap = 2'd0; wr_ant = 2'd1;
        wr_re = 8'h55; wr_im = 8'hAA;
      end else if (disturb && n == 4) begin
        start = 1'b0; wr_en = 1'b0;
      end else if (disturb && n == k + 6) begin
        wr_en = 1'b1; wr_lane = 2'd2; wr_step = 2'd0; wr_tap = 2'd1; wr_ant = 2'd0;
        wr_re = 8'h11; wr_im = 8'h22;
      end else if (disturb && n == k + 7) begin
        wr_en = 1'b0;
      end
    end
    chk(lat_ok, "R11", "valid window matches K+4 latency", lat_ok, 1);
    chk(busy_ok, "R8", "busy window", busy_ok, 1);
    chk(words == w, "R6", "word count", words, w);
  endtask

  initial begin
    int unsigned seed_set;
    seed_set = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(busy == 1'b0, "R8", "busy in reset", busy, 0);
    chk(vis_valid == 1'b0, "R8", "valid in reset", vis_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R8", "busy after reset", busy, 0);

    // R2: directed conjugate product on known values
    for (int l = 0; l < NLANE; l++)
      for (int s = 0; s < MAXSTEP; s++)
        for (int t = 0; t < NTAP; t++)
          for (int a = 0; a < NANT; a++)
            put(l, s, t, a, 0, 0);
    put(0, 0, 0, 0, 3, 4);
    put(0, 0, 0, 1, 1, -2);
    put(1, 0, 2, 2, -128, 127);
    put(1, 0, 2, 3, 127, -128);
    put_end();
    run(1, 1, 0, "R2");

    // R3: random data, several step counts
    fill_random();
    run(2, 2, 0, "R3");
    run(3, 3, 0, "R3");

    // R4: clamping of the step count
    fill_random();
    run(0, 1, 0, "R4");
    run(7, 4, 0, "R4");

    // R7, R9, R10: rerun on the same samples with interference while busy
    run(4, 4, 1, "R7,R9,R10");
    run(4, 4, 0, "R10");

    // R5: saturation in both directions
    for (int l = 0; l < NLANE; l++)
      for (int s = 0; s < MAXSTEP; s++)
        for (int t = 0; t < NTAP; t++)
          for (int a = 0; a < NANT; a++)
            if ((a + l) % 2 == 0) put(l, s, t, a, 127, 127);
            else                  put(l, s, t, a, -128, -128);
    put_end();
    run(4, 4, 0, "R5");
    chk(exp_re(0, 0, 1, 4) == -LIM, "R5", "model reaches negative clamp", exp_re(0, 0, 1, 4), -LIM);

    // R6: lanes with different random content, long run
    fill_random();
    run(4, 4, 0, "R6");

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule